// File: doc/BRIEF.md
# Receive Buffer with Link Pause/Resume Requests

This block is the per-port receive buffer that sits behind a serial link receiver. Words arrive from the link side on an active-low source-ready/destination-ready interface. They leave toward the local consumer on a second active-low handshake, in arrival order, and only while the port's dataflow enable is high. A single clock drives everything.

The buffer watches its own occupancy and asks the link transmitter to send pause (XOFF) or resume (XON) symbols to the far end. It raises a pause request once half the storage is in use. It raises a resume request once occupancy falls back under the half mark. It always raises one resume request after reset, because an earlier connection may have left the partner stopped.

Requests use a request/acknowledge pair. A request stays up with a stable kind until the transmitter acknowledges it. A new request is raised only when the wanted state differs from the last acknowledged one. The upper half of the storage is the headroom that absorbs words the partner sends before it obeys a pause.

Top module: `rx_flow_fifo`

## Requirements
- R1: While reset is held and right after it is released, the block shows the following: `fifoEmpty`=1, `fifoFull`=0, `outSrcRdyN`=1, `inDstRdyN`=0, `backPres`=0, `overflow`=0, and a pending request `fcReq`=1 with `fcXoff`=0 (resume).
- R2: A word offered with `inSrcRdyN`=0 while the buffer is not full is stored. Stored words leave on `outData` in the order they arrived, with none lost or duplicated.
- R3: A word leaves only on a clock edge where `outSrcRdyN`=0 and `outDstRdyN`=0. `outSrcRdyN` is 1 whenever the buffer is empty or `flowEn` is 0. While the consumer stalls, `outData` holds the head word and occupancy does not change.
- R4: `inDstRdyN` and `fifoFull` are 1 exactly when DEPTH words are held, and 0 otherwise.
- R5: A word offered while the buffer is full is discarded, leaving the contents unchanged. It sets `overflow`, which stays 1 until reset.
- R6: `backPres` is 1 whenever occupancy is at least DEPTH/2, and 0 below that.
- R7: If the last acknowledged command was resume, `fcReq` rises with `fcXoff`=1 (pause) one clock after occupancy reaches DEPTH/2.
- R8: If the last acknowledged command was pause, `fcReq` rises with `fcXoff`=0 (resume) one clock after occupancy falls below DEPTH/2.
- R9: A raised request keeps `fcReq`=1 and a stable `fcXoff` until a clock edge where `fcAck`=1. It is low after that edge. No new request appears while the wanted state equals the last acknowledged one, so there is never a repeated pause while the buffer stays above half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | W | Word from the link receiver |
| inSrcRdyN | input | 1 | Active-low: link side offers `inData` |
| inDstRdyN | output | 1 | Active-low: buffer can take a word (high when full) |
| outData | output | W | Head word toward the consumer |
| outSrcRdyN | output | 1 | Active-low: a word is offered on `outData` |
| outDstRdyN | input | 1 | Active-low: consumer accepts the offered word |
| flowEn | input | 1 | Dataflow enable for the output side |
| fcReq | output | 1 | Flow-control symbol request to the transmitter |
| fcXoff | output | 1 | Kind of the request: 1 pause, 0 resume |
| fcAck | input | 1 | Transmitter has taken the request |
| backPres | output | 1 | Occupancy is at or above half |
| fifoFull | output | 1 | DEPTH words held |
| fifoEmpty | output | 1 | No word held |
| overflow | output | 1 | Sticky: a word was discarded because the buffer was full |

## Verification
The bench fills the buffer exactly to the half mark. A design with an off-by-one threshold would raise pause one word late, or raise back-pressure at the wrong occupancy. The bench then drains exactly to one word under half and expects a single resume. It also leaves a request unacknowledged for several cycles and holds the buffer above half after an acknowledge, which exposes a design that drops the request early or repeats the pause. Words pushed into a full buffer must vanish from the output order while the sticky flag stays set. Streaming with simultaneous push and pop, a disabled output and a stalled consumer catch designs that lose, duplicate or release words without the full handshake.

// File: rtl/rxff_pkg.sv
package rxff_pkg;

  // Strobes from control to the datapath
  typedef struct packed {
    logic push;
    logic pop;
  } rxff_strobe_t;

  // Flow-control command kinds
  typedef enum logic {
    CMD_XON  = 1'b0,
    CMD_XOFF = 1'b1
  } fc_cmd_e;

endpackage

// File: rtl/rxff_datapath.sv
module rxff_datapath
  import rxff_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  rxff_strobe_t strb,
  input  logic [W-1:0] inData,
  output logic [W-1:0] outData,
  output logic         full,
  output logic         empty,
  output logic         atHalf
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + AW'(1);
      if (strb.pop)  rdPtr <= rdPtr + AW'(1);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign outData = mem[rdPtr];
  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign atHalf  = (count >= HALF_CNT);

  // R5: control never writes into a full buffer
  a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strb.push);

  // R3: control never pops an empty buffer
  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !strb.pop);

  // R2: occupancy moves by at most one per clock
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (count == $past(count)) || (count == $past(count) + CW'(1)) ||
    (count == $past(count) - CW'(1)));

endmodule

// File: rtl/rxff_control.sv
module rxff_control
  import rxff_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inSrcRdyN,
  input  logic         outDstRdyN,
  input  logic         flowEn,
  input  logic         fcAck,
  input  logic         full,
  input  logic         empty,
  input  logic         atHalf,
  output rxff_strobe_t strb,
  output logic         inDstRdyN,
  output logic         outSrcRdyN,
  output logic         fcReq,
  output logic         fcXoff,
  output logic         backPres,
  output logic         overflow
);

  logic    reqPend;
  fc_cmd_e reqKind;
  fc_cmd_e sentKind;
  fc_cmd_e wantKind;

  assign outSrcRdyN = empty | ~flowEn;
  assign inDstRdyN  = full;
  assign strb.push  = ~inSrcRdyN & ~full;
  assign strb.pop   = ~outSrcRdyN & ~outDstRdyN;
  assign backPres   = atHalf;
  assign wantKind   = atHalf ? CMD_XOFF : CMD_XON;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPend  <= 1'b1;
      reqKind  <= CMD_XON;
      sentKind <= CMD_XOFF;
      overflow <= 1'b0;
    end else begin
      if (!inSrcRdyN && full) overflow <= 1'b1;
      if (reqPend) begin
        if (fcAck) begin
          reqPend  <= 1'b0;
          sentKind <= reqKind;
        end
      end else if (wantKind != sentKind) begin
        reqPend <= 1'b1;
        reqKind <= wantKind;
      end
    end
  end

  assign fcReq  = reqPend;
  assign fcXoff = (reqKind == CMD_XOFF);

  // R9: a request holds with a stable kind until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    reqPend && !fcAck |=> reqPend && $stable(reqKind));

  // R9: an acknowledged request drops on the next cycle
  a_r9_req_release: assert property (@(posedge clk) disable iff (!rstN)
    reqPend && fcAck |=> !reqPend);

  // R5: overflow flag is sticky
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo
  import rxff_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] inData,
  input  logic         inSrcRdyN,
  output logic         inDstRdyN,
  output logic [W-1:0] outData,
  output logic         outSrcRdyN,
  input  logic         outDstRdyN,
  input  logic         flowEn,
  output logic         fcReq,
  output logic         fcXoff,
  input  logic         fcAck,
  output logic         backPres,
  output logic         fifoFull,
  output logic         fifoEmpty,
  output logic         overflow
);

  generate
    if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_badDepth
      $error("DEPTH must be a power of two of at least 4");
    end
  endgenerate

  rxff_strobe_t strb;
  logic full;
  logic empty;
  logic atHalf;

  rxff_datapath #(.W(W), .DEPTH(DEPTH)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .inData (inData),
    .outData(outData),
    .full   (full),
    .empty  (empty),
    .atHalf (atHalf)
  );

  rxff_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .inSrcRdyN (inSrcRdyN),
    .outDstRdyN(outDstRdyN),
    .flowEn    (flowEn),
    .fcAck     (fcAck),
    .full      (full),
    .empty     (empty),
    .atHalf    (atHalf),
    .strb      (strb),
    .inDstRdyN (inDstRdyN),
    .outSrcRdyN(outSrcRdyN),
    .fcReq     (fcReq),
    .fcXoff    (fcXoff),
    .backPres  (backPres),
    .overflow  (overflow)
  );

  assign fifoFull  = full;
  assign fifoEmpty = empty;

endmodule

// File: tb/tb_rx_flow_fifo.sv
`timescale 1ns/1ps
module tb_rx_flow_fifo;

  localparam int W     = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rstN;
  logic [W-1:0] inData;
  logic inSrcRdyN, inDstRdyN;
  logic [W-1:0] outData;
  logic outSrcRdyN, outDstRdyN, flowEn;
  logic fcReq, fcXoff, fcAck;
  logic backPres, fifoFull, fifoEmpty, overflow;

  int total = 0;
  int bad = 0;
  int modelCount = 0;
  bit done = 0;
  logic [W-1:0] expQ[$];

  always #4 clk = ~clk;

  rx_flow_fifo #(.W(W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inSrcRdyN(inSrcRdyN),
    .inDstRdyN(inDstRdyN), .outData(outData), .outSrcRdyN(outSrcRdyN),
    .outDstRdyN(outDstRdyN), .flowEn(flowEn), .fcReq(fcReq),
    .fcXoff(fcXoff), .fcAck(fcAck), .backPres(backPres),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .overflow(overflow)
  );

  task automatic checkEq(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pop, sampled mid-cycle before the next edge
  always @(negedge clk) begin
    #2;
    if (rstN === 1'b1 && outSrcRdyN === 1'b0 && outDstRdyN === 1'b0) begin
      if (expQ.size() == 0) begin
        checkEq("R2", "unexpected word", outData, 0);
      end else begin
        checkEq("R2", "order", outData, expQ.pop_front());
        modelCount--;
      end
    end
  end

  // Driver: offer one word; the model accepts it only when not full
  task automatic pushWord(logic [W-1:0] d);
    @(negedge clk);
    inSrcRdyN = 1'b0;
    inData = d;
    if (modelCount < DEPTH) begin
      expQ.push_back(d);
      modelCount++;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    inSrcRdyN = 1'b1;
    #2;
  endtask

  task automatic ackReq(logic expXoff, string req);
    checkEq(req, "request up before ack", fcReq, 1);
    checkEq(req, "request kind", fcXoff, expXoff);
    @(negedge clk);
    fcAck = 1'b1;
    @(negedge clk);
    fcAck = 1'b0;
    #2;
    checkEq("R9", "request low after ack", fcReq, 0);
  endtask

  task automatic checkReset();
    checkEq("R1", "empty", fifoEmpty, 1);
    checkEq("R1", "full", fifoFull, 0);
    checkEq("R1", "outSrcRdyN", outSrcRdyN, 1);
    checkEq("R1", "inDstRdyN", inDstRdyN, 0);
    checkEq("R1", "backPres", backPres, 0);
    checkEq("R1", "overflow", overflow, 0);
    checkEq("R1", "resume request", fcReq, 1);
    checkEq("R1", "resume kind", fcXoff, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inSrcRdyN = 1'b1; inData = '0;
    outDstRdyN = 1'b1; flowEn = 1'b0; fcAck = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    checkReset();
    @(negedge clk);
    rstN = 1'b1;
    #2;
    checkReset();
    repeat (3) @(negedge clk);
    #2;
    checkEq("R9", "unacked reset request held", fcReq, 1);
    ackReq(1'b0, "R1");

    // Fill to one under half, then to half: threshold corner
    for (int i = 0; i < DEPTH/2 - 1; i++) pushWord(32'h100 + i);
    idle();
    checkEq("R6", "backPres below half", backPres, 0);
    checkEq("R7", "no pause below half", fcReq, 0);
    pushWord(32'h1ff);
    idle();
    checkEq("R6", "backPres at half", backPres, 1);
    @(negedge clk); #2;
    checkEq("R7", "pause request", fcReq, 1);
    checkEq("R7", "pause kind", fcXoff, 1);

    // Fill to full plus two dropped words
    for (int i = 0; i < DEPTH/2 + 2; i++) pushWord(32'h200 + i);
    idle();
    checkEq("R4", "inDstRdyN full", inDstRdyN, 1);
    checkEq("R4", "fifoFull", fifoFull, 1);
    checkEq("R5", "overflow set", overflow, 1);
    checkEq("R9", "pause still pending", fcReq, 1);
    ackReq(1'b1, "R7");
    repeat (3) @(negedge clk); #2;
    checkEq("R9", "no repeated pause", fcReq, 0);

    // Output disabled: consumer ready yet nothing moves
    outDstRdyN = 1'b0;
    repeat (3) @(negedge clk); #2;
    checkEq("R3", "outSrcRdyN when disabled", outSrcRdyN, 1);
    checkEq("R3", "no move when disabled", fifoFull, 1);
    outDstRdyN = 1'b1;
    flowEn = 1'b1;
    #1;
    checkEq("R3", "offer when enabled", outSrcRdyN, 0);
    repeat (2) @(negedge clk); #2;
    checkEq("R3", "head held on stall", outData, 32'h100);
    checkEq("R3", "no move on stall", fifoFull, 1);

    // Drain to one below half
    @(negedge clk);
    outDstRdyN = 1'b0;
    repeat (DEPTH/2 + 1) @(negedge clk);
    outDstRdyN = 1'b1;
    #2;
    checkEq("R6", "backPres below half after drain", backPres, 0);
    checkEq("R4", "not full after drain", inDstRdyN, 0);
    checkEq("R8", "no resume yet", fcReq, 0);
    @(negedge clk); #2;
    checkEq("R8", "resume request", fcReq, 1);
    checkEq("R8", "resume kind", fcXoff, 0);
    ackReq(1'b0, "R8");

    // Drain the rest
    @(negedge clk);
    outDstRdyN = 1'b0;
    repeat (DEPTH) @(negedge clk);
    #2;
    checkEq("R2", "all words delivered", expQ.size(), 0);
    checkEq("R3", "outSrcRdyN when empty", outSrcRdyN, 1);
    checkEq("R9", "no request while resumed", fcReq, 0);

    // Streaming push with pop each cycle
    for (int i = 0; i < 20; i++) pushWord(32'h300 + i);
    idle();
    repeat (3) @(negedge clk); #2;
    checkEq("R2", "stream delivered", expQ.size(), 0);
    checkEq("R9", "no request while streaming", fcReq, 0);
    checkEq("R6", "no backPres while streaming", backPres, 0);

    // Intermittent consumer
    outDstRdyN = 1'b1;
    for (int i = 0; i < 5; i++) pushWord(32'h400 + i);
    idle();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      outDstRdyN = i[0];
    end
    @(negedge clk);
    outDstRdyN = 1'b0;
    repeat (4) @(negedge clk); #2;
    checkEq("R2", "intermittent delivered", expQ.size(), 0);
    checkEq("R5", "overflow sticky", overflow, 1);

    // Reset with data held
    outDstRdyN = 1'b1;
    for (int i = 0; i < 3; i++) pushWord(32'h500 + i);
    idle();
    rstN = 1'b0;
    expQ.delete();
    modelCount = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #2;
    checkReset();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule